// File: doc/BRIEF.md
# Page program write splitter

This block turns one host write request (start address, byte count, and a byte stream) into a series of page-program transactions for a serial NOR flash. Each piece it carves off stays inside one flash page and fits the transmit FIFO in front of the serial engine. It drives the shared command-engine request interface, which also serves the erase sequencer, and it pushes program data into the transmit FIFO as 32-bit words.

For every piece the block first reads the flash status until the device is no longer busy. It then sets the write-enable latch, loads the FIFO, issues the program command, and reads status again until the device finishes. A piece that ends with the latch still set was not taken by the flash. That piece is sent again from a local copy, and the host stream is not re-read. The outcome is reported once per request as a result code together with the number of bytes that landed.

Top module: `page_write_splitter`

## Requirements
- R1: Each program command carries length min(256 − (address mod 256), bytes still to write, 64) and the address where that piece starts, so no piece crosses a 256-byte page.
- R2: Before each program attempt the block issues status reads (opcode 0x05, length 1, address 0) until status bit 0 (busy) reads 0. It then issues write enable (opcode 0x06, length 0, address 0).
- R3: After write enable and before the program command (opcode 0x02), the piece is pushed as ceil(len/4) words. Byte k of the piece sits in bits [8·(k mod 4)+7 : 8·(k mod 4)], unused lanes of the last word are 0xFF, and every word leaves before the command is raised.
- R4: After the program command, status reads repeat while bit 0 is 1. If bit 0 is 0 and bit 1 (write-enable latch) is 1, the piece is retried from the busy check with the same data and no new stream bytes, and it is not counted.
- R5: The third failed attempt within one request (the count does not restart per piece) ends the request with result 3, and the count holds the bytes of the pieces that completed.
- R6: A command completion flagged as an error ends the request at once with result 2, and the count holds the bytes of the pieces that completed.
- R7: A request with address + length ≥ DEV_BYTES ends with result 2'd1 and count 0. It issues no command and takes no stream byte.
- R8: A request that completes returns result 0 with count equal to the requested length. A zero-length request returns result 0 and count 0 with no command.
- R9: While a command request waits for the engine to accept it, the request and its opcode, address and length stay unchanged.
- R10: `done` is a one-cycle pulse raised while `busy` is already low. A new request is taken only while `busy` is low.
- R11: After reset, `busy`, `in_ready`, `cmd_valid`, `tx_valid` and `done` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a write (taken while busy is low) |
| req_addr | input | AW | Flash byte address of the write |
| req_len | input | LW | Byte count of the write |
| busy | output | 1 | A write is in progress |
| in_valid | input | 1 | Host byte available |
| in_byte | input | 8 | Host data byte |
| in_ready | output | 1 | Block takes the byte this cycle if in_valid |
| cmd_valid | output | 1 | Command request to the serial engine |
| cmd_op | output | 8 | Flash opcode |
| cmd_addr | output | AW | Flash address of the command |
| cmd_len | output | clog2(FIFO_BYTES+1) | Data length of the command |
| cmd_ready | input | 1 | Engine accepts the request |
| cmd_done | input | 1 | Engine finished the accepted command |
| cmd_err | input | 1 | Finished command failed |
| cmd_status | input | 2 | Status byte bits: 0 busy, 1 write-enable latch |
| tx_valid | output | 1 | Push tx_word into the transmit FIFO |
| tx_word | output | 32 | Program data word |
| done | output | 1 | Request finished (one cycle) |
| done_result | output | 2 | 0 ok, 1 rejected, 2 transfer error, 3 retries exhausted |
| done_count | output | LW | Bytes written by the request |

## Verification
The assertions assume that the engine raises `cmd_done` only once per accepted command, never in the same cycle as the acceptance, and only while the block waits for it. They also assume that the transmit FIFO is empty at the start of each piece, so it never refuses a word. The bench engine model follows these rules: after each handshake it answers exactly two cycles later and holds `cmd_ready` low on a fixed pattern. The host stream inserts gaps, but it always holds at least the bytes the request announces.

// File: rtl/pws_pkg.sv
package pws_pkg;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_PROG = 8'h02;

  localparam int SR_WIP = 0;
  localparam int SR_WEL = 1;

  typedef enum logic [1:0] {
    RES_OK     = 2'd0,
    RES_REJECT = 2'd1,
    RES_XFER   = 2'd2,
    RES_GIVEUP = 2'd3
  } result_e;

  typedef enum logic [1:0] {
    P_CHK  = 2'd0,
    P_WEN  = 2'd1,
    P_PRG  = 2'd2,
    P_POLL = 2'd3
  } phase_e;

  typedef enum logic [2:0] {
    S_IDLE, S_PREP, S_FILL, S_CMD, S_WAIT, S_LOAD, S_END
  } state_e;

  function automatic logic [7:0] op_of(phase_e p);
    case (p)
      P_PRG:   return OP_PROG;
      P_WEN:   return OP_WREN;
      default: return OP_RDSR;
    endcase
  endfunction
endpackage

// File: rtl/pws_chunk_len.sv
module pws_chunk_len #(
  parameter int LW         = 16,
  parameter int PAGE_BYTES = 256,
  parameter int FIFO_BYTES = 64,
  localparam int PB  = $clog2(PAGE_BYTES),
  localparam int CLW = $clog2(FIFO_BYTES + 1)
) (
  input  logic [PB-1:0]  page_off,
  input  logic [LW-1:0]  remain,
  output logic [CLW-1:0] len
);
  localparam logic [PB:0] PAGE_L = (PB+1)'(PAGE_BYTES);
  localparam logic [PB:0] CAP_L  = (PB+1)'(FIFO_BYTES);

  logic [PB:0] room;
  logic [PB:0] lim;

  always_comb begin
    room = PAGE_L - {1'b0, page_off};
    lim  = (room < CAP_L) ? room : CAP_L;
    if (remain < LW'(lim)) len = CLW'(remain);
    else                   len = CLW'(lim);
  end
endmodule

// File: rtl/pws_word_buf.sv
module pws_word_buf #(
  parameter int FIFO_BYTES = 64,
  localparam int DW = FIFO_BYTES / 4,
  localparam int IW = $clog2(DW),
  localparam int BW = $clog2(FIFO_BYTES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [BW-1:0] wr_pos,
  input  logic [7:0]    wr_byte,
  input  logic          wr_last,
  input  logic          rd_en,
  input  logic [IW-1:0] rd_idx,
  output logic          rd_valid,
  output logic [31:0]   rd_word
);
  logic [31:0] mem [DW];
  logic [31:0] acc;
  logic [31:0] merged;
  logic [1:0]  lane;
  logic        commit;

  assign lane   = wr_pos[1:0];
  assign commit = wr_en && (lane == 2'd3 || wr_last);

  always_comb begin
    merged = acc;
    merged[8*lane +: 8] = wr_byte;
  end

  // packer: unused lanes of a short last word keep the erased value
  always_ff @(posedge clk) begin
    if (rst)         acc <= '1;
    else if (commit) acc <= '1;
    else if (wr_en)  acc <= merged;
  end

  // storage written without reset so it maps to block RAM
  always_ff @(posedge clk) begin
    if (commit) mem[wr_pos[BW-1:2]] <= merged;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_word <= mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) rd_valid <= 1'b0;
    else     rd_valid <= rd_en;
  end
endmodule

// File: rtl/page_write_splitter.sv
module page_write_splitter
  import pws_pkg::*;
#(
  parameter int AW         = 24,
  parameter int LW         = 16,
  parameter int PAGE_BYTES = 256,
  parameter int FIFO_BYTES = 64,
  parameter int MAX_TRIES  = 3,
  parameter int DEV_BYTES  = 1 << 24
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               req_valid,
  input  logic [AW-1:0]                      req_addr,
  input  logic [LW-1:0]                      req_len,
  output logic                               busy,
  input  logic                               in_valid,
  input  logic [7:0]                         in_byte,
  output logic                               in_ready,
  output logic                               cmd_valid,
  output logic [7:0]                         cmd_op,
  output logic [AW-1:0]                      cmd_addr,
  output logic [$clog2(FIFO_BYTES+1)-1:0]    cmd_len,
  input  logic                               cmd_ready,
  input  logic                               cmd_done,
  input  logic                               cmd_err,
  input  logic [1:0]                         cmd_status,
  output logic                               tx_valid,
  output logic [31:0]                        tx_word,
  output logic                               done,
  output logic [1:0]                         done_result,
  output logic [LW-1:0]                      done_count
);
  localparam int CLW = $clog2(FIFO_BYTES + 1);
  localparam int BW  = $clog2(FIFO_BYTES);
  localparam int IW  = $clog2(FIFO_BYTES / 4);
  localparam int PB  = $clog2(PAGE_BYTES);
  localparam int TW  = $clog2(MAX_TRIES + 1);
  localparam logic [AW:0]  DEV_L   = (AW+1)'(DEV_BYTES);
  localparam logic [TW-1:0] LAST_T = TW'(MAX_TRIES - 1);

  state_e          state;
  phase_e          phase;
  result_e         res;
  logic [AW-1:0]   cur_addr;
  logic [LW-1:0]   remain;
  logic [LW-1:0]   written;
  logic [CLW-1:0]  clen;
  logic [CLW-1:0]  fill_cnt;
  logic [CLW-1:0]  rd_idx;
  logic [CLW-1:0]  nwords;
  logic [CLW-1:0]  chunk_now;
  logic [TW-1:0]   tries;
  logic [AW:0]     req_end;

  logic wip, wel, ok_done;
  logic accept_byte, last_byte, rd_en;
  logic chunk_ok, wel_fail;
  logic   issue;
  phase_e issue_ph;

  assign busy        = (state != S_IDLE);
  assign in_ready    = (state == S_FILL);
  assign wip         = cmd_status[SR_WIP];
  assign wel         = cmd_status[SR_WEL];
  assign ok_done     = (state == S_WAIT) && cmd_done && !cmd_err;
  assign accept_byte = in_valid && in_ready;
  assign last_byte   = accept_byte && (fill_cnt == clen - 1'b1);
  assign nwords      = (clen + CLW'(3)) >> 2;
  assign rd_en       = (state == S_LOAD) && (rd_idx < nwords);
  assign chunk_ok    = ok_done && (phase == P_POLL) && !wip && !wel;
  assign wel_fail    = ok_done && (phase == P_POLL) && !wip && wel;
  assign req_end     = {1'b0, req_addr} + (AW+1)'(req_len);

  pws_chunk_len #(
    .LW(LW), .PAGE_BYTES(PAGE_BYTES), .FIFO_BYTES(FIFO_BYTES)
  ) u_len (
    .page_off (cur_addr[PB-1:0]),
    .remain   (remain),
    .len      (chunk_now)
  );

  pws_word_buf #(.FIFO_BYTES(FIFO_BYTES)) u_buf (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (accept_byte),
    .wr_pos   (fill_cnt[BW-1:0]),
    .wr_byte  (in_byte),
    .wr_last  (last_byte),
    .rd_en    (rd_en),
    .rd_idx   (rd_idx[IW-1:0]),
    .rd_valid (tx_valid),
    .rd_word  (tx_word)
  );

  // which command, if any, is raised at the next edge
  always_comb begin
    issue    = 1'b0;
    issue_ph = phase;
    case (state)
      S_FILL: if (last_byte) begin
        issue = 1'b1; issue_ph = P_CHK;
      end
      S_WAIT: if (ok_done) begin
        case (phase)
          P_CHK: begin issue = 1'b1; issue_ph = wip ? P_CHK : P_WEN; end
          P_PRG: begin issue = 1'b1; issue_ph = P_POLL; end
          P_POLL: begin
            if (wip) begin
              issue = 1'b1; issue_ph = P_POLL;
            end else if (wel && tries != LAST_T) begin
              issue = 1'b1; issue_ph = P_CHK;
            end
          end
          default: ;
        endcase
      end
      S_LOAD: if (rd_idx == nwords && !tx_valid) begin
        issue = 1'b1; issue_ph = P_PRG;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_IDLE;
      phase       <= P_CHK;
      res         <= RES_OK;
      cur_addr    <= '0;
      remain      <= '0;
      written     <= '0;
      clen        <= '0;
      fill_cnt    <= '0;
      rd_idx      <= '0;
      tries       <= '0;
      cmd_valid   <= 1'b0;
      cmd_op      <= '0;
      cmd_addr    <= '0;
      cmd_len     <= '0;
      done        <= 1'b0;
      done_result <= '0;
      done_count  <= '0;
    end else begin
      done <= 1'b0;
      if (accept_byte) fill_cnt <= fill_cnt + 1'b1;
      if (rd_en)       rd_idx   <= rd_idx + 1'b1;
      if (wel_fail)    tries    <= tries + 1'b1;

      if (issue) begin
        state     <= S_CMD;
        phase     <= issue_ph;
        cmd_valid <= 1'b1;
        cmd_op    <= op_of(issue_ph);
        cmd_addr  <= (issue_ph == P_PRG) ? cur_addr : '0;
        if (issue_ph == P_PRG)      cmd_len <= clen;
        else if (issue_ph == P_WEN) cmd_len <= '0;
        else                        cmd_len <= CLW'(1);
      end else begin
        case (state)
          S_IDLE: if (req_valid) begin
            written  <= '0;
            tries    <= '0;
            cur_addr <= req_addr;
            remain   <= req_len;
            if (req_len == '0) begin
              res <= RES_OK;     state <= S_END;
            end else if (req_end >= DEV_L) begin
              res <= RES_REJECT; state <= S_END;
            end else begin
              state <= S_PREP;
            end
          end
          S_PREP: begin
            clen     <= chunk_now;
            fill_cnt <= '0;
            state    <= S_FILL;
          end
          S_CMD: if (cmd_ready) begin
            cmd_valid <= 1'b0;
            state     <= S_WAIT;
          end
          S_WAIT: if (cmd_done) begin
            if (cmd_err) begin
              res <= RES_XFER; state <= S_END;
            end else if (phase == P_WEN) begin
              rd_idx <= '0;
              state  <= S_LOAD;
            end else if (chunk_ok) begin
              written  <= written + LW'(clen);
              cur_addr <= cur_addr + AW'(clen);
              remain   <= remain - LW'(clen);
              if (remain == LW'(clen)) begin
                res <= RES_OK; state <= S_END;
              end else begin
                state <= S_PREP;
              end
            end else if (wel_fail) begin
              res <= RES_GIVEUP; state <= S_END;
            end
          end
          S_END: begin
            done        <= 1'b1;
            done_result <= res;
            done_count  <= written;
            state       <= S_IDLE;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/pws_checker.sv
module pws_checker
  import pws_pkg::*;
#(
  parameter int AW         = 24,
  parameter int LW         = 16,
  parameter int PAGE_BYTES = 256,
  parameter int FIFO_BYTES = 64,
  localparam int CLW = $clog2(FIFO_BYTES + 1),
  localparam int PB  = $clog2(PAGE_BYTES)
) (
  input logic           clk,
  input logic           rst,
  input logic           busy,
  input logic           in_ready,
  input logic           cmd_valid,
  input logic [7:0]     cmd_op,
  input logic [AW-1:0]  cmd_addr,
  input logic [CLW-1:0] cmd_len,
  input logic           cmd_ready,
  input logic           tx_valid,
  input logic           done,
  input logic [1:0]     done_result,
  input logic [LW-1:0]  done_count
);
  logic [CLW-1:0] word_cnt;

  always_ff @(posedge clk) begin
    if (rst) word_cnt <= '0;
    else if (cmd_valid && cmd_ready && cmd_op == OP_PROG) word_cnt <= '0;
    else if (tx_valid) word_cnt <= word_cnt + 1'b1;
  end

  p_page_fit_r1: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == OP_PROG) |->
      (cmd_len != '0 && cmd_len <= CLW'(FIFO_BYTES) &&
       ({1'b0, cmd_addr[PB-1:0]} + (PB+1)'(cmd_len)) <= (PB+1)'(PAGE_BYTES)));

  p_words_first_r3: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> !cmd_valid);

  p_word_count_r3: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready && cmd_op == OP_PROG) |->
      (word_cnt == ((cmd_len + CLW'(3)) >> 2)));

  p_fill_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> (!cmd_valid && !tx_valid));

  p_reject_count_r7: assert property (@(posedge clk) disable iff (rst)
    (done && done_result == RES_REJECT) |-> (done_count == '0));

  p_hold_req_r9: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_ready) |=>
      (cmd_valid && $stable(cmd_op) && $stable(cmd_addr) && $stable(cmd_len)));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_idle_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

bind page_write_splitter pws_checker #(
  .AW(AW), .LW(LW), .PAGE_BYTES(PAGE_BYTES), .FIFO_BYTES(FIFO_BYTES)
) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .in_ready(in_ready),
  .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
  .cmd_len(cmd_len), .cmd_ready(cmd_ready), .tx_valid(tx_valid),
  .done(done), .done_result(done_result), .done_count(done_count)
);

// File: tb/tb_page_write_splitter.sv
module tb_page_write_splitter;
  localparam int CLK_PERIOD = 10;
  localparam int AW  = 24;
  localparam int LW  = 16;
  localparam int CLW = 7;
  localparam int DEV = 1 << 24;

  typedef struct {
    logic [7:0] op;
    int         addr;
    int         len;
  } cmd_t;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           req_valid = 1'b0;
  logic [AW-1:0]  req_addr = '0;
  logic [LW-1:0]  req_len = '0;
  logic           busy;
  logic           in_valid = 1'b0;
  logic [7:0]     in_byte = '0;
  logic           in_ready;
  logic           cmd_valid;
  logic [7:0]     cmd_op;
  logic [AW-1:0]  cmd_addr;
  logic [CLW-1:0] cmd_len;
  logic           cmd_ready = 1'b0;
  logic           cmd_done = 1'b0;
  logic           cmd_err = 1'b0;
  logic [1:0]     cmd_status = '0;
  logic           tx_valid;
  logic [31:0]    tx_word;
  logic           done;
  logic [1:0]     done_result;
  logic [LW-1:0]  done_count;

  page_write_splitter dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_len(req_len), .busy(busy), .in_valid(in_valid), .in_byte(in_byte),
    .in_ready(in_ready), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_ready(cmd_ready),
    .cmd_done(cmd_done), .cmd_err(cmd_err), .cmd_status(cmd_status),
    .tx_valid(tx_valid), .tx_word(tx_word), .done(done),
    .done_result(done_result), .done_count(done_count)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_t        exp_cmd[$];
  logic [2:0]  resp_q[$];
  logic [31:0] exp_word[$];
  logic [7:0]  stream_q[$];
  int exp_res, exp_cnt, ncmd, seed;
  int checks = 0;
  int errors = 0;
  bit mon_en = 0;
  bit op_done = 0;
  string cur_req = "R8";

  task automatic check(bit ok, string req, string what, longint act, longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic logic [7:0] pat(int i);
    return 8'((i * 29 + seed) & 255);
  endfunction

  task automatic add(logic [7:0] op, int ad, int ln, logic [1:0] st, inout bit stop);
    cmd_t c;
    c.op = op; c.addr = ad; c.len = ln;
    exp_cmd.push_back(c);
    if (ncmd == -100) ; // placeholder never true
    resp_q.push_back({1'b0, st});
    ncmd++;
  endtask

  // reference model: expected commands, responses, words and outcome
  task automatic build(int addr, int len, int busy_n, int fail_mask, int err_idx);
    int a, rem, off, tries, att, c, nw;
    bit stop, fail;
    logic [31:0] w;
    ncmd = 0; exp_cnt = 0; exp_res = 0;
    if (len == 0) return;
    if (addr + len >= DEV) begin exp_res = 1; return; end
    a = addr; rem = len; off = 0; tries = 0; att = 0; stop = 0;
    while (rem > 0 && !stop) begin
      c = 256 - (a % 256);
      if (c > 64) c = 64;
      if (rem < c) c = rem;
      while (!stop) begin
        for (int i = 0; i <= busy_n; i++) begin
          add(8'h05, 0, 1, (i < busy_n) ? 2'b01 : 2'b00, stop);
          if (ncmd - 1 == err_idx) begin stop = 1; resp_q[$] = 3'b100; exp_res = 2; break; end
        end
        if (stop) break;
        add(8'h06, 0, 0, 2'b00, stop);
        if (ncmd - 1 == err_idx) begin stop = 1; resp_q[$] = 3'b100; exp_res = 2; break; end
        nw = (c + 3) / 4;
        for (int k = 0; k < nw; k++) begin
          w = '1;
          for (int b = 0; b < 4; b++)
            if (4*k + b < c) w[8*b +: 8] = pat(off + 4*k + b);
          exp_word.push_back(w);
        end
        add(8'h02, a, c, 2'b00, stop);
        if (ncmd - 1 == err_idx) begin stop = 1; resp_q[$] = 3'b100; exp_res = 2; break; end
        for (int i = 0; i < busy_n; i++) begin
          add(8'h05, 0, 1, 2'b01, stop);
          if (ncmd - 1 == err_idx) begin stop = 1; resp_q[$] = 3'b100; exp_res = 2; break; end
        end
        if (stop) break;
        fail = fail_mask[att];
        att++;
        add(8'h05, 0, 1, fail ? 2'b10 : 2'b00, stop);
        if (ncmd - 1 == err_idx) begin stop = 1; resp_q[$] = 3'b100; exp_res = 2; break; end
        if (!fail) begin
          exp_cnt += c; a += c; off += c; rem -= c;
          break;
        end
        tries++;
        if (tries == 3) begin stop = 1; exp_res = 3; end
      end
    end
  endtask

  // engine model and per-cycle comparison against the reference queues
  initial begin
    int cd = 0;
    int cyc = 0;
    logic [2:0] pend = '0;
    bit prev_stall = 0;
    bit prev_done = 0;
    logic [7:0] p_op = '0;
    logic [AW-1:0] p_addr = '0;
    logic [CLW-1:0] p_len = '0;
    cmd_t h;
    forever begin
      @(negedge clk);
      if (!mon_en) continue;
      cmd_done = 1'b0;
      if (cd > 0) begin
        cd--;
        if (cd == 0) begin
          cmd_done = 1'b1; cmd_err = pend[2]; cmd_status = pend[1:0];
        end
      end
      if (prev_stall)
        check(cmd_valid && cmd_op == p_op && cmd_addr == p_addr && cmd_len == p_len,
              "R9", "held request", {cmd_op, cmd_addr}, {p_op, p_addr});
      if (prev_done) check(!done, "R10", "done pulse width", done, 0);
      prev_done = done;
      if (tx_valid) begin
        if (exp_word.size() == 0) check(0, "R3", "unexpected word", tx_word, 0);
        else begin
          logic [31:0] ew;
          ew = exp_word.pop_front();
          check(tx_word == ew, "R3", "fifo word", tx_word, ew);
        end
      end
      cmd_ready = (cyc % 4 != 1);
      if (cmd_valid && cmd_ready) begin
        if (exp_cmd.size() == 0) check(0, "R2", "unexpected command", cmd_op, 0);
        else begin
          h = exp_cmd.pop_front();
          check(cmd_op == h.op, (h.op == 8'h02) ? "R3" : "R2", "opcode", cmd_op, h.op);
          check(int'(cmd_addr) == h.addr && int'(cmd_len) == h.len, "R1",
                "addr/len", {cmd_addr, 1'b0, cmd_len}, {h.addr[AW-1:0], 1'b0, h.len[CLW-1:0]});
          pend = resp_q.pop_front();
          cd = 2;
        end
      end
      prev_stall = cmd_valid && !cmd_ready;
      p_op = cmd_op; p_addr = cmd_addr; p_len = cmd_len;
      in_valid = (stream_q.size() > 0) && (cyc % 5 != 2);
      in_byte  = (stream_q.size() > 0) ? stream_q[0] : 8'h00;
      if (in_valid && in_ready) void'(stream_q.pop_front());
      if (done) begin
        check(!busy, "R10", "busy at done", busy, 0);
        check(done_result == 2'(exp_res), cur_req, "result", done_result, exp_res);
        check(int'(done_count) == exp_cnt, cur_req, "count", done_count, exp_cnt);
        op_done = 1;
      end
      cyc++;
    end
  end

  task automatic run(string req, int addr, int len, int busy_n, int mask, int err_idx);
    int t = 0;
    cur_req = req;
    seed = seed + 53;
    exp_cmd.delete(); resp_q.delete(); exp_word.delete(); stream_q.delete();
    for (int i = 0; i < len; i++) stream_q.push_back(pat(i));
    build(addr, len, busy_n, mask, err_idx);
    op_done = 0;
    @(negedge clk);
    check(!busy, "R10", "idle before request", busy, 0);
    req_valid = 1'b1; req_addr = AW'(addr); req_len = LW'(len);
    @(negedge clk);
    req_valid = 1'b0;
    while (!op_done && t < 20000) begin @(negedge clk); t++; end
    check(op_done, req, "completion", op_done, 1);
    check(exp_cmd.size() == 0, req, "commands left", exp_cmd.size(), 0);
    check(exp_word.size() == 0, "R3", "words left", exp_word.size(), 0);
    if (exp_res == 0) check(stream_q.size() == 0, "R4", "stream bytes left", stream_q.size(), 0);
    if (exp_res == 1) check(stream_q.size() == len, "R7", "stream bytes left", stream_q.size(), len);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    seed = 7;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !in_ready && !cmd_valid && !tx_valid && !done, "R11", "reset outputs",
          {busy, in_ready, cmd_valid, tx_valid, done}, 0);
    mon_en = 1;
    run("R8", 'h10, 8, 0, 0, -1);
    run("R1", 'hF0, 100, 2, 0, -1);
    run("R3", 'h200, 7, 1, 0, -1);
    run("R1", 'hFFFFF5, 10, 0, 0, -1);
    run("R7", 'hFFFFF6, 10, 0, 0, -1);
    run("R4", 'h300, 10, 1, 1, -1);
    run("R5", 'h400, 70, 0, 13, -1);
    run("R6", 'h500, 80, 0, 0, 5);
    run("R6", 'h600, 12, 1, 0, 3);
    run("R8", 'h700, 0, 0, 0, -1);
    run("R2", 'h7F8, 20, 3, 0, -1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule